// File: doc/BRIEF.md
# Firmware Record Stream Loader

This block accepts a firmware image one byte at a time over a valid/ready stream and writes the image's payload into on-chip memory through a single-byte write port. The image opens with a fixed 12-byte header: a 4-byte version word, then the byte size of the main section, then the byte size of a trailing microcode section. All three fields are little-endian. The main section follows the header at once and is a chain of records. Each record holds a 4-byte destination address, a 2-byte payload length and that many payload bytes, with both numeric fields little-endian.

The loader accepts the image only when the version word's low byte matches the expected major number. It walks the records and writes each payload byte to the next higher address. It checks every record against the main-section bytes still unread. The microcode section is consumed without being written. The loader then reports completion, or it reports an error when the version is wrong, a record is malformed or the stream ends early. After either outcome the block holds its state until reset.

Top module: `fw_stream_loader`

## Requirements
- R1: After reset, `done`, `error` and `wrEn` are low and `inReady` is high.
- R2: The header is 12 bytes. Bytes 0-3 hold the version word, bytes 4-7 the main-section size and bytes 8-11 the microcode size, each field least significant byte first. When both sizes are zero, `done` rises in the cycle after byte 11 is accepted.
- R3: If header byte 0 (the version's low byte) differs from `MAJOR_VER` (default 1), the image is rejected: `error` rises and no write is issued. The version's upper bytes are ignored.
- R4: A record is a 4-byte destination and a 2-byte length, both least significant byte first, followed by the payload. The i-th payload byte (counting from 0) is written at destination+i, with `wrEn` high for one cycle in the cycle after that byte is accepted.
- R5: A record whose length is zero is legal and produces no write.
- R6: If a record starts while fewer than 6 main-section bytes remain, `error` rises and nothing more is written.
- R7: If a record's length exceeds the main-section bytes left after its length field, `error` rises and none of its payload is written.
- R8: Record parsing stops exactly when the main-section byte count is used up. The bytes that follow are microcode and are never written, even if they are laid out like a record.
- R9: After the last microcode byte is accepted, `done` rises in the next cycle, `inReady` drops, and no write follows.
- R10: After an error the loader keeps `inReady` high and discards bytes until a byte marked `inLast` is accepted. It then drops `inReady`.
- R11: A byte marked `inLast` that arrives before the image's declared end raises `error`, and that byte is not written.
- R12: `done` and `error` never rise together, and each stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input byte is valid |
| inData | input | 8 | Input byte |
| inLast | input | 1 | Marks the final byte of the image |
| inReady | output | 1 | Loader can take a byte |
| wrEn | output | 1 | Memory byte write strobe |
| wrAddr | output | ADDR_W | Memory write address |
| wrData | output | 8 | Memory write byte |
| done | output | 1 | Image loaded successfully |
| error | output | 1 | Image rejected |

## Verification
A well-formed image that mixes a multi-byte record, a zero-length record and a microcode tail is sent once back-to-back and once with idle cycles between bytes. Matching write logs from the two runs show that parsing depends only on accepted bytes and not on timing. Separate images each contain exactly one fault: a wrong version byte, a record header cut off by the section size, a payload that overruns the section, and a stream that ends early. Each of these must produce the error flag with only the writes that come before the fault, and every byte through the end marker must be accepted. A final image puts record-shaped bytes in the microcode section to show that parsing stops at the declared main-section size.

// File: rtl/fwl_pkg.sv
package fwl_pkg;

  localparam int HDR_BYTES     = 12;
  localparam int REC_HDR_BYTES = 6;
  localparam int SIZE_W        = 32;
  localparam int LEN_W         = 16;

  typedef enum logic [2:0] {
    ST_HDR,
    ST_REC,
    ST_PAY,
    ST_UC,
    ST_DRAIN,
    ST_DONE,
    ST_FAIL
  } loadState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       capHdr;
    logic       capRec;
    logic [3:0] byteSel;
    logic       mainDec;
    logic       ucDec;
    logic       payWrite;
  } dpCmd_t;

  // conditions from datapath to control
  typedef struct packed {
    logic verOk;
    logic mainZero;
    logic ucFinalZero;
    logic ucZero;
    logic mainShort;
    logic lenOver;
    logic lenZero;
    logic mainOne;
    logic payOne;
    logic ucOne;
  } dpStat_t;

endpackage

// File: rtl/fwl_datapath.sv
module fwl_datapath
  import fwl_pkg::*;
#(
  parameter int         ADDR_W    = 32,
  parameter logic [7:0] MAJOR_VER = 8'd1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [7:0]        inData,
  output dpStat_t           stat,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData
);

  logic [7:0]        verByte;
  logic [SIZE_W-1:0] mainLeft;
  logic [SIZE_W-1:0] ucLeft;
  logic [31:0]       dstRaw;
  logic [7:0]        lenLo;
  logic [LEN_W-1:0]  payLeft;
  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  lenNow;

  assign lenNow = {inData, lenLo};

  always_comb begin
    stat.verOk       = (verByte == MAJOR_VER);
    stat.mainZero    = (mainLeft == '0);
    stat.ucFinalZero = ({inData, ucLeft[23:0]} == 32'd0);
    stat.ucZero      = (ucLeft == '0);
    stat.mainShort   = (mainLeft < SIZE_W'(REC_HDR_BYTES));
    stat.lenOver     = (SIZE_W'(lenNow) > (mainLeft - SIZE_W'(1)));
    stat.lenZero     = (lenNow == '0);
    stat.mainOne     = (mainLeft == SIZE_W'(1));
    stat.payOne      = (payLeft == LEN_W'(1));
    stat.ucOne       = (ucLeft == SIZE_W'(1));
  end

  // header fields and section counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      verByte  <= '0;
      mainLeft <= '0;
      ucLeft   <= '0;
    end else begin
      if (cmd.capHdr) begin
        case (cmd.byteSel)
          4'd0:    verByte         <= inData;
          4'd4:    mainLeft[7:0]   <= inData;
          4'd5:    mainLeft[15:8]  <= inData;
          4'd6:    mainLeft[23:16] <= inData;
          4'd7:    mainLeft[31:24] <= inData;
          4'd8:    ucLeft[7:0]     <= inData;
          4'd9:    ucLeft[15:8]    <= inData;
          4'd10:   ucLeft[23:16]   <= inData;
          4'd11:   ucLeft[31:24]   <= inData;
          default: ;
        endcase
      end
      if (cmd.mainDec) mainLeft <= mainLeft - SIZE_W'(1);
      if (cmd.ucDec)   ucLeft   <= ucLeft - SIZE_W'(1);
    end
  end

  // record fields, address walk and write port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dstRaw  <= '0;
      lenLo   <= '0;
      payLeft <= '0;
      curAddr <= '0;
      wrEn    <= 1'b0;
      wrAddr  <= '0;
      wrData  <= '0;
    end else begin
      wrEn <= 1'b0;
      if (cmd.capRec) begin
        case (cmd.byteSel)
          4'd0: dstRaw[7:0]   <= inData;
          4'd1: dstRaw[15:8]  <= inData;
          4'd2: dstRaw[23:16] <= inData;
          4'd3: dstRaw[31:24] <= inData;
          4'd4: lenLo         <= inData;
          4'd5: begin
            payLeft <= lenNow;
            curAddr <= dstRaw[ADDR_W-1:0];
          end
          default: ;
        endcase
      end
      if (cmd.payWrite) begin
        wrEn    <= 1'b1;
        wrAddr  <= curAddr;
        wrData  <= inData;
        curAddr <= curAddr + ADDR_W'(1);
        payLeft <= payLeft - LEN_W'(1);
      end
    end
  end

endmodule

// File: rtl/fwl_ctrl.sv
module fwl_ctrl
  import fwl_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    inLast,
  input  dpStat_t stat,
  output dpCmd_t  cmd,
  output logic    inReady,
  output logic    done,
  output logic    error
);

  loadState_t state;
  loadState_t nxt;
  loadState_t afterMain;
  logic [3:0] byteIdx;
  logic [3:0] idxNxt;
  logic       acc;
  logic       truncate;

  always_comb begin
    inReady   = (state != ST_DONE) && (state != ST_FAIL);
    acc       = inValid && inReady;
    cmd       = '0;
    nxt       = state;
    idxNxt    = byteIdx;
    afterMain = stat.ucZero ? ST_DONE : ST_UC;
    case (state)
      ST_HDR: begin
        cmd.capHdr  = acc;
        cmd.byteSel = byteIdx;
        if (acc) begin
          if (byteIdx == 4'(HDR_BYTES - 1)) begin
            idxNxt = '0;
            if (!stat.verOk)        nxt = ST_DRAIN;
            else if (stat.mainZero) nxt = stat.ucFinalZero ? ST_DONE : ST_UC;
            else                    nxt = ST_REC;
          end else begin
            idxNxt = byteIdx + 4'd1;
          end
        end
      end
      ST_REC: begin
        cmd.capRec  = acc;
        cmd.byteSel = byteIdx;
        cmd.mainDec = acc;
        if (acc) begin
          if (byteIdx == 4'd0 && stat.mainShort) begin
            nxt = ST_DRAIN;
          end else if (byteIdx == 4'(REC_HDR_BYTES - 1)) begin
            idxNxt = '0;
            if (stat.lenOver)      nxt = ST_DRAIN;
            else if (stat.lenZero) nxt = stat.mainOne ? afterMain : ST_REC;
            else                   nxt = ST_PAY;
          end else begin
            idxNxt = byteIdx + 4'd1;
          end
        end
      end
      ST_PAY: begin
        cmd.mainDec = acc;
        if (acc && stat.payOne) nxt = stat.mainOne ? afterMain : ST_REC;
      end
      ST_UC: begin
        cmd.ucDec = acc;
        if (acc && stat.ucOne) nxt = ST_DONE;
      end
      ST_DRAIN: begin
        if (acc && inLast) nxt = ST_FAIL;
      end
      default: ;
    endcase
    // an end marker anywhere short of completion ends the image as failed
    truncate = acc && inLast && (nxt != ST_DONE);
    if (truncate) nxt = ST_FAIL;
    cmd.payWrite = (state == ST_PAY) && acc && !truncate;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_HDR;
      byteIdx <= '0;
    end else begin
      state   <= nxt;
      byteIdx <= idxNxt;
    end
  end

  assign done  = (state == ST_DONE);
  assign error = (state == ST_DRAIN) || (state == ST_FAIL);

endmodule

// File: rtl/fw_stream_loader.sv
module fw_stream_loader
  import fwl_pkg::*;
#(
  parameter int         ADDR_W    = 32,
  parameter logic [7:0] MAJOR_VER = 8'd1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [7:0]        inData,
  input  logic              inLast,
  output logic              inReady,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              done,
  output logic              error
);

  dpCmd_t  cmd;
  dpStat_t stat;

  fwl_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inLast  (inLast),
    .stat    (stat),
    .cmd     (cmd),
    .inReady (inReady),
    .done    (done),
    .error   (error)
  );

  fwl_datapath #(
    .ADDR_W    (ADDR_W),
    .MAJOR_VER (MAJOR_VER)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .inData (inData),
    .stat   (stat),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData)
  );

endmodule

// File: rtl/fwl_checks.sv
module fwl_checks #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              done,
  input logic              error
);

  // R4
  ascending_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && $past(wrEn)) |-> (wrAddr == $past(wrAddr) + ADDR_W'(1)));

  // R10
  no_write_on_error_chk: assert property (@(posedge clk) disable iff (!rstN)
    error |-> !wrEn);

  // R9
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !wrEn);

  // R12
  sticky_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (done && !error));

  // R12
  sticky_error_chk: assert property (@(posedge clk) disable iff (!rstN)
    error |=> (error && !done));

  // R9
  done_follows_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(inValid));

endmodule

bind fw_stream_loader fwl_checks #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .done    (done),
  .error   (error)
);

// File: tb/fw_stream_loader_test.sv
module fw_stream_loader_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inData = '0;
  logic        inLast = 1'b0;
  logic        inReady;
  logic        wrEn;
  logic [31:0] wrAddr;
  logic [7:0]  wrData;
  logic        done;
  logic        error;

  int nChk = 0;
  int nFail = 0;

  logic [7:0]  img [0:127];
  int          imgLen = 0;
  logic [31:0] wA [0:63];
  logic [7:0]  wD [0:63];
  int          wCount = 0;
  int          accepted = 0;
  logic        doneNext = 1'b0;

  always #10 clk = ~clk;

  fw_stream_loader uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inLast(inLast), .inReady(inReady), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .done(done), .error(error)
  );

  always @(negedge clk) begin
    if (rstN && wrEn && wCount < 64) begin
      wA[wCount] = wrAddr;
      wD[wCount] = wrData;
      wCount++;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put8(input logic [7:0] b);
    img[imgLen] = b;
    imgLen++;
  endtask

  task automatic put16(input logic [15:0] v);
    put8(v[7:0]); put8(v[15:8]);
  endtask

  task automatic put32(input logic [31:0] v);
    put8(v[7:0]); put8(v[15:8]); put8(v[23:16]); put8(v[31:24]);
  endtask

  task automatic header(input logic [31:0] ver, input logic [31:0] mainSz, input logic [31:0] ucSz);
    imgLen = 0;
    put32(ver); put32(mainSz); put32(ucSz);
  endtask

  task automatic doReset();
    inValid = 1'b0; inLast = 1'b0; inData = '0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    wCount = 0;
    @(negedge clk);
  endtask

  task automatic sendImage(input int gap);
    accepted = 0;
    doneNext = 1'b0;
    for (int i = 0; i < imgLen; i++) begin
      if (!inReady) break;
      inValid = 1'b1;
      inData  = img[i];
      inLast  = (i == imgLen - 1);
      accepted++;
      @(negedge clk);
      inValid = 1'b0;
      inLast  = 1'b0;
      if (i == imgLen - 1) doneNext = done;
      repeat (gap) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic testReset();
    doReset();
    chk("R1 done", done, 0);
    chk("R1 error", error, 0);
    chk("R1 wrEn", wrEn, 0);
    chk("R1 inReady", inReady, 1);
  endtask

  task automatic testGood(input int gap, input logic [31:0] ver);
    doReset();
    header(ver, 32'd23, 32'd5);
    put32(32'h0000_1000); put16(16'd3); put8(8'hA1); put8(8'hA2); put8(8'hA3);
    put32(32'h0000_0777); put16(16'd0);
    put32(32'h0000_0020); put16(16'd2); put8(8'hB1); put8(8'hB2);
    for (int k = 0; k < 5; k++) put8(8'hE0 + 8'(k));
    sendImage(gap);
    chk("R4 R5 write count", wCount, 5);
    chk("R4 addr0", wA[0], 32'h1000); chk("R4 data0", wD[0], 8'hA1);
    chk("R4 addr2", wA[2], 32'h1002); chk("R4 data2", wD[2], 8'hA3);
    chk("R4 addr3", wA[3], 32'h0020); chk("R4 data4", wD[4], 8'hB2);
    chk("R9 done next cycle", doneNext, 1);
    chk("R9 inReady low", inReady, 0);
    chk("R12 no error", error, 0);
    repeat (5) @(negedge clk);
    chk("R12 done held", done, 1);
    chk("R2 all bytes taken", accepted, imgLen);
  endtask

  task automatic testBadVersion();
    doReset();
    header(32'h0000_0102, 32'd9, 32'd2);
    put32(32'h0000_0100); put16(16'd3); put8(8'h11); put8(8'h22); put8(8'h33);
    put8(8'h44); put8(8'h55);
    sendImage(0);
    chk("R3 error", error, 1);
    chk("R3 no writes", wCount, 0);
    chk("R10 drained to last", accepted, imgLen);
    chk("R10 inReady low", inReady, 0);
    chk("R12 no done", done, 0);
  endtask

  task automatic testShortRecord();
    doReset();
    header(32'h0000_0001, 32'd4, 32'd0);
    put8(8'h01); put8(8'h02); put8(8'h03); put8(8'h04);
    sendImage(0);
    chk("R6 error", error, 1);
    chk("R6 no writes", wCount, 0);
    chk("R10 drained", accepted, imgLen);
  endtask

  task automatic testOverrun();
    doReset();
    header(32'h0000_0001, 32'd10, 32'd0);
    put32(32'h0000_0040); put16(16'd5);
    put8(8'h91); put8(8'h92); put8(8'h93); put8(8'h94);
    sendImage(1);
    chk("R7 error", error, 1);
    chk("R7 no writes", wCount, 0);
    chk("R10 drained", accepted, imgLen);
  endtask

  task automatic testTruncated();
    doReset();
    header(32'h0000_0001, 32'd10, 32'd3);
    put32(32'h0000_0300); put16(16'd4); put8(8'h5A); put8(8'h5B);
    sendImage(0);
    chk("R11 error", error, 1);
    chk("R11 one write", wCount, 1);
    chk("R11 write addr", wA[0], 32'h300);
    chk("R11 write data", wD[0], 8'h5A);
    chk("R11 no done", done, 0);
    chk("R11 inReady low", inReady, 0);
  endtask

  task automatic testEmpty();
    doReset();
    header(32'h0000_0001, 32'd0, 32'd0);
    sendImage(0);
    chk("R2 done after header", doneNext, 1);
    chk("R2 no writes", wCount, 0);
  endtask

  task automatic testSectionEnd();
    doReset();
    header(32'h0000_0001, 32'd9, 32'd7);
    put32(32'h0000_0050); put16(16'd3); put8(8'hC1); put8(8'hC2); put8(8'hC3);
    put32(32'h0000_0000); put16(16'd2); put8(8'hDD);
    sendImage(0);
    chk("R8 only main writes", wCount, 3);
    chk("R8 last addr", wA[2], 32'h52);
    chk("R8 done", done, 1);
    chk("R8 no error", error, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    testReset();
    testGood(0, 32'h0000_0301);
    testGood(2, 32'h7F00_0001);
    testBadVersion();
    testShortRecord();
    testOverrun();
    testTruncated();
    testEmpty();
    testSectionEnd();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule